// File: doc/BRIEF.md
# DRAM Channel Event Counter Unit

This block is a performance monitoring unit for one DRAM controller channel. It has eight 48-bit counters. Each counter has an 8-bit event selector that picks what it counts: clock cycles, write data beats or read data beats. The controller supplies the beat pulses on two inputs. Software programs and reads the unit through a small register bus. The bus carries a global run bit, a per-counter enable register, per-counter event selectors, and counters that software can preload. It also carries overflow status with a write-one-to-clear register, an interrupt mask and a single interrupt line.

A two-state bus sequencer serves register accesses. In state S_IDLE it waits for `bus_req` and latches the address, direction and write data. The transition S_IDLE to S_ACCESS is taken on `bus_req`. In S_ACCESS it commits a write or captures read data. The transition S_ACCESS to S_IDLE is always taken and raises `bus_ack` for one cycle. Requests that arrive outside S_IDLE are not taken. Every access takes two clock edges.

Top module: `pmu_ddr_evcnt`

## Requirements
- R1: After reset, every counter, every event selector, the run bit, the enable register, the overflow status and `irq` are 0, and the interrupt mask reads 0xFF (all counters masked).
- R2: Counter n sits at offset 0x200 + 8·n. A write loads bits 47:0 of the write data. A read returns the 48-bit value with bits 63:48 at zero.
- R3: The event selector of counter n sits at offset 0x100 + 4·n. Only bits 7:0 are stored, and the upper bits read back as zero.
- R4: Selector code 0x00 adds one on every clock edge, code 0x83 adds one on each edge where `evt_wr_beat` is 1, and code 0x84 adds one on each edge where `evt_rd_beat` is 1. Every other code leaves the counter unchanged. A counter adds at most one per edge.
- R5: Bit 0 at offset 0x000 is the run bit. While it is 0, no counter changes, except through a bus write to that counter.
- R6: Bit n at offset 0x004 enables counter n. A counter advances only when both its enable bit and the run bit are 1.
- R7: A counter that advances from 0xFFFF_FFFF_FFFF wraps to 0 and sets overflow status bit n. This happens whether the counter is masked or not.
- R8: Overflow status is read at offset 0x00C. Writing to offset 0x010 clears each status bit whose write-data bit is 1, and bits written as 0 leave their status unchanged. Offset 0x010 reads as 0.
- R9: Bit n at offset 0x008 set to 1 masks counter n. `irq` is a register that takes the OR over n of (status n AND NOT mask n), so it follows a status or mask change one clock later.
- R10: Reads of any offset not listed above, including misaligned counter or selector offsets, return 0.
- R11: `bus_req` sampled in S_IDLE moves the sequencer to S_ACCESS. A write takes effect on the next edge. `bus_ack` is high for exactly one cycle after that edge, with read data valid on `bus_rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, sampled in S_IDLE |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_ack | output | 1 | One-cycle access completion |
| bus_rdata | output | 64 | Read data, valid with bus_ack |
| evt_wr_beat | input | 1 | Write data beat pulse from the controller |
| evt_rd_beat | input | 1 | Read data beat pulse from the controller |
| irq | output | 1 | Registered overflow interrupt |

## Verification
Assertions check on every cycle that a counter stays frozen while it is not allowed to count and is not written. They also check that a counting step adds exactly one, that a step from the all-ones value wraps to zero, that an overflow always lands in the status, that status bits stay set until cleared, and that `bus_ack` never lasts two cycles. Only the bench scenarios can show the things that involve the register map: the offset decode, the selector code table against the two beat inputs, and the exact count over a run window. The same applies to the way the mask and the clear word act together on `irq`, including its one-cycle lag.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int ADDR_W = 12;
    localparam int BUS_W  = 64;

    localparam logic [ADDR_W-1:0] OFS_RUN   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EN    = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h010;
    localparam int                SEL_BASE  = 'h100;
    localparam int                SEL_STEP  = 4;
    localparam int                CNT_BASE  = 'h200;
    localparam int                CNT_STEP  = 8;

    localparam logic [7:0] EV_CYCLE  = 8'h00;
    localparam logic [7:0] EV_WRBEAT = 8'h83;
    localparam logic [7:0] EV_RDBEAT = 8'h84;

    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_ACCESS = 1'b1
    } bus_st_e;
endpackage

// File: rtl/pmu_bus_fsm.sv
module pmu_bus_fsm
    import pmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BUS_W-1:0]  acc_wdata,
    output logic              bus_ack
);
    bus_st_e state_q, state_d;
    logic    we_q;
    logic    ack_q;

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            we_q      <= 1'b0;
            acc_addr  <= '0;
            acc_wdata <= '0;
            ack_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= (state_q == S_ACCESS);
            if (state_q == S_IDLE && bus_req) begin
                we_q      <= bus_we;
                acc_addr  <= bus_addr;
                acc_wdata <= bus_wdata;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (bus_req) state_d = S_ACCESS;
            S_ACCESS: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        acc_rd = 1'b0;
        acc_wr = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_ACCESS: begin
                acc_wr = we_q;
                acc_rd = !we_q;
            end
            default:  ;
        endcase
    end

    assign bus_ack = ack_q;

    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             evt_wr_beat,
    input  logic             evt_rd_beat,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic hit, step;

    always_comb begin
        if (sel == SEL_W'(EV_CYCLE))       hit = 1'b1;
        else if (sel == SEL_W'(EV_WRBEAT)) hit = evt_wr_beat;
        else if (sel == SEL_W'(EV_RDBEAT)) hit = evt_rd_beat;
        else                               hit = 1'b0;
    end

    assign step = count_en && hit && !cnt_we;
    assign ovf  = step && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
            cnt <= '0;
        end else begin
            if (sel_we) sel <= sel_wdata;
            if (cnt_we)    cnt <= cnt_wdata;
            else if (step) cnt <= cnt + 1'b1;
        end
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !cnt_we) |=> $stable(cnt));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == '0));
endmodule

// File: rtl/pmu_irq.sv
module pmu_irq #(
    parameter int N_CNT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CNT-1:0] ovf,
    input  logic             clr_we,
    input  logic             mask_we,
    input  logic [N_CNT-1:0] wbits,
    output logic [N_CNT-1:0] mask,
    output logic [N_CNT-1:0] stat,
    output logic             irq
);
    logic [N_CNT-1:0] clr_bits;
    assign clr_bits = clr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
            stat <= '0;
            irq  <= 1'b0;
        end else begin
            if (mask_we) mask <= wbits;
            stat <= (stat & ~clr_bits) | ovf;
            irq  <= |(stat & ~mask);
        end
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_chk
        p_ovf_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[i] |=> stat[i]);
        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !clr_bits[i]) |=> stat[i]);
    end
endmodule

// File: rtl/pmu_ddr_evcnt.sv
module pmu_ddr_evcnt
    import pmu_pkg::*;
#(
    parameter int N_CNT = 8,
    parameter int CNT_W = 48,
    parameter int SEL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic              bus_ack,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              evt_wr_beat,
    input  logic              evt_rd_beat,
    output logic              irq
);
    logic              acc_rd, acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic [BUS_W-1:0]  acc_wdata;

    logic              run_q;
    logic [N_CNT-1:0]  en_q;
    logic [N_CNT-1:0]  mask, stat, ovf;
    logic [N_CNT-1:0]  sel_we, cnt_we;
    logic [SEL_W-1:0]  sel [N_CNT];
    logic [CNT_W-1:0]  cnt [N_CNT];
    logic [BUS_W-1:0]  rd_val;
    logic              unused_hi;

    assign unused_hi = ^acc_wdata[BUS_W-1:CNT_W];

    pmu_bus_fsm u_bus (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .bus_ack(bus_ack)
    );

    // Write decode for per-counter registers
    always_comb begin
        for (int i = 0; i < N_CNT; i++) begin
            sel_we[i] = acc_wr && (acc_addr == ADDR_W'(SEL_BASE + SEL_STEP * i));
            cnt_we[i] = acc_wr && (acc_addr == ADDR_W'(CNT_BASE + CNT_STEP * i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            en_q  <= '0;
        end else if (acc_wr) begin
            if (acc_addr == OFS_RUN) run_q <= acc_wdata[0];
            if (acc_addr == OFS_EN)  en_q  <= acc_wdata[N_CNT-1:0];
        end
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        pmu_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .count_en(run_q && en_q[i]),
            .evt_wr_beat(evt_wr_beat), .evt_rd_beat(evt_rd_beat),
            .sel_we(sel_we[i]), .sel_wdata(acc_wdata[SEL_W-1:0]),
            .cnt_we(cnt_we[i]), .cnt_wdata(acc_wdata[CNT_W-1:0]),
            .sel(sel[i]), .cnt(cnt[i]), .ovf(ovf[i])
        );
    end

    pmu_irq #(.N_CNT(N_CNT)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .ovf(ovf),
        .clr_we(acc_wr && acc_addr == OFS_CLR),
        .mask_we(acc_wr && acc_addr == OFS_MASK),
        .wbits(acc_wdata[N_CNT-1:0]),
        .mask(mask), .stat(stat), .irq(irq)
    );

    // Read mux
    always_comb begin
        rd_val = '0;
        if (acc_addr == OFS_RUN)  rd_val = BUS_W'(run_q);
        if (acc_addr == OFS_EN)   rd_val = BUS_W'(en_q);
        if (acc_addr == OFS_MASK) rd_val = BUS_W'(mask);
        if (acc_addr == OFS_STAT) rd_val = BUS_W'(stat);
        for (int i = 0; i < N_CNT; i++) begin
            if (acc_addr == ADDR_W'(SEL_BASE + SEL_STEP * i)) rd_val = BUS_W'(sel[i]);
            if (acc_addr == ADDR_W'(CNT_BASE + CNT_STEP * i)) rd_val = BUS_W'(cnt[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (acc_rd) bus_rdata <= rd_val;
    end
endmodule

// File: tb/tb_pmu_ddr_evcnt.sv
module tb_pmu_ddr_evcnt;
    localparam logic [47:0] MAXV = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_ack;
    logic [63:0] bus_rdata;
    logic        ev_w = 1'b0, ev_r = 1'b0;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pmu_ddr_evcnt dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .evt_wr_beat(ev_w), .evt_rd_beat(ev_r),
        .irq(irq)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each bus task is entered at a falling edge and returns at one.
    task automatic bus_wr(input logic [11:0] a, input logic [63:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [63:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
        check("R11 ack with read data", {63'b0, bus_ack}, 64'd1);
        d = bus_rdata;
    endtask

    function automatic logic [47:0] exp_cnt(input logic [47:0] pre, input logic [7:0] code,
                                            input bit on, input int nc, input int nw, input int nr);
        int inc;
        inc = 0;
        if (on) begin
            if (code == 8'h00)      inc = nc;
            else if (code == 8'h83) inc = nw;
            else if (code == 8'h84) inc = nr;
        end
        return pre + 48'(inc);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [63:0] rd;
        logic [47:0] pre [8];
        logic [7:0]  code [8];
        logic [7:0]  en;
        bit          run_on;
        int          nc, nw, nr, nl;

        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq after reset", {63'b0, irq}, 64'd0);
        bus_rd(12'h000, rd); check("R1 run", rd, 64'd0);
        bus_rd(12'h004, rd); check("R1 enables", rd, 64'd0);
        bus_rd(12'h008, rd); check("R1 mask", rd, 64'hFF);
        bus_rd(12'h00C, rd); check("R1 status", rd, 64'd0);
        bus_rd(12'h200, rd); check("R1 counter0", rd, 64'd0);
        bus_rd(12'h238, rd); check("R1 counter7", rd, 64'd0);
        bus_rd(12'h11C, rd); check("R1 selector7", rd, 64'd0);

        // R2, R3: register widths
        bus_wr(12'h218, 64'hFFFF_1234_5678_9ABC);
        bus_rd(12'h218, rd); check("R2 counter3 width", rd, 64'h0000_1234_5678_9ABC);
        bus_wr(12'h108, 64'h0000_0000_ABCD_1283);
        bus_rd(12'h108, rd); check("R3 selector2 width", rd, 64'h83);

        // R10: unmapped offsets
        bus_rd(12'h050, rd); check("R10 offset 0x050", rd, 64'd0);
        bus_rd(12'h120, rd); check("R10 offset 0x120", rd, 64'd0);
        bus_rd(12'h204, rd); check("R10 offset 0x204", rd, 64'd0);
        bus_rd(12'h010, rd); check("R10 clear reg reads 0", rd, 64'd0);

        // Random rounds: R4, R5, R6
        for (int r = 0; r < 24; r++) begin
            bus_wr(12'h000, 64'd0);
            bus_wr(12'h010, 64'hFF);
            for (int i = 0; i < 8; i++) begin
                case ($urandom % 5)
                    0: code[i] = 8'h00;
                    1: code[i] = 8'h83;
                    2: code[i] = 8'h84;
                    3: code[i] = 8'h85;
                    default: code[i] = 8'($urandom);
                endcase
                pre[i] = {16'h0, 32'($urandom)};
                bus_wr(12'(12'h100 + 4 * i), {56'h0, code[i]});
                bus_wr(12'(12'h200 + 8 * i), {16'h0, pre[i]});
            end
            en = 8'($urandom);
            bus_wr(12'h004, {56'h0, en});
            run_on = (r == 0) ? 1'b0 : ($urandom % 4 != 0);
            if (run_on) bus_wr(12'h000, 64'd1);
            nl = 5 + int'($urandom % 40);
            nw = 0; nr = 0;
            for (int k = 0; k < nl; k++) begin
                ev_w = 1'($urandom); ev_r = 1'($urandom);
                if (ev_w) nw++;
                if (ev_r) nr++;
                @(negedge clk);
            end
            ev_w = 1'b0; ev_r = 1'b0;
            // the stop write spans two counting edges with events low
            nc = nl + 2;
            bus_wr(12'h000, 64'd0);
            for (int i = 0; i < 8; i++) begin
                bus_rd(12'(12'h200 + 8 * i), rd);
                check(run_on ? "R4 R6 counter after run" : "R5 counter with run off",
                      rd, {16'h0, exp_cnt(pre[i], code[i], run_on && en[i], nc, nw, nr)});
            end
        end

        // R7, R8, R9: overflow, clear and masking
        bus_wr(12'h010, 64'hFF);
        bus_wr(12'h118, 64'h00);
        bus_wr(12'h128, 64'h00);
        bus_wr(12'h10C, 64'h00);
        bus_wr(12'h114, 64'h00);
        bus_wr(12'h218, {16'h0, MAXV - 48'd3});
        bus_wr(12'h228, {16'h0, MAXV - 48'd1});
        bus_wr(12'h004, 64'h28);
        bus_wr(12'h008, 64'hF7);
        bus_wr(12'h000, 64'd1);
        repeat (2) @(negedge clk);
        bus_wr(12'h000, 64'd0);
        bus_rd(12'h218, rd); check("R7 counter3 wraps to 0", rd, 64'd0);
        bus_rd(12'h228, rd); check("R7 counter5 wraps to 2", rd, 64'd2);
        bus_rd(12'h00C, rd); check("R7 status incl masked counter5", rd, 64'h28);
        check("R9 irq from unmasked counter3", {63'b0, irq}, 64'd1);
        bus_wr(12'h010, 64'h08);
        check("R9 irq lags clear by one cycle", {63'b0, irq}, 64'd1);
        @(negedge clk);
        check("R9 irq low with only masked status", {63'b0, irq}, 64'd0);
        bus_rd(12'h00C, rd); check("R8 zero bits keep status", rd, 64'h20);
        bus_wr(12'h008, 64'hD7);
        @(negedge clk);
        check("R9 unmask raises irq", {63'b0, irq}, 64'd1);
        bus_wr(12'h010, 64'h20);
        @(negedge clk);
        check("R8 clear drops irq", {63'b0, irq}, 64'd0);
        bus_rd(12'h00C, rd); check("R8 status cleared", rd, 64'd0);

        summary();
    end
endmodule